// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns a single programmed operation into the complete byte-level bus sequence that a raw NAND flash device expects. Software loads two address registers, a byte count, an optional second-command register and then writes a start word. The engine then works through the operation on its own, in this order:

- a first command cycle;
- zero to eight address cycles;
- an optional second command;
- an optional read or write data phase through an internal page buffer;
- a wait on the device's ready/busy line.

When the operation ends, the engine raises sticky completion flags that software clears by writing ones.

The second command of a pair is placed according to the operation type. On a read it follows the address bytes, and the data phase waits until the device reports ready again. On a program it follows the last write data byte. Every bus cycle pulses a write or read strobe low for a fixed number of clocks, then high for a fixed number of clocks. After the last command or data cycle the engine ignores ready/busy for a settle window, so that a stale ready level taken before the device has dropped the line cannot end the operation early.

A host-side port gives the page buffer load and unload access while the engine is idle.

Top module: `nand_seq_top`

## Requirements
- R1: After reset the status word (register 6, bit 0 = busy) and the interrupt register (register 5) read 0, CLE and ALE are low, WE_n and RE_n are high, and while idle the engine drives no strobe.
- R2: A write to register 0 with bit 31 set starts an operation; its first bus cycle is a command cycle (CLE high, ALE low) carrying bits 7:0 of that word.
- R3: When bit 30 of the start word is set, bits 29:27 plus one address cycles follow the first command with ALE high. Their bytes come from register 1 bits 15:0 and then register 2 bits 31:0, least significant byte first; byte positions beyond these are zero.
- R4: A read (start bit 26) with bit 30 clear still emits exactly one address cycle, carrying register 1 bits 7:0.
- R5: When register 3 bit 8 is set, a second command cycle carries register 3 bits 7:0. On a read or a data-less operation it follows the last address byte. On a write (start bit 25) it follows the last data byte.
- R6: A value N in register 4 moves N+1 data bytes. Read bytes are stored in the page buffer at indices 0..N, each captured as RE_n rises. Write bytes are taken from buffer indices 0..N in order. Buffer entries above N are untouched.
- R7: After the last command or data bus cycle the engine ignores R/B_n for SETTLE_CYC clocks. It then waits for R/B_n high before it reads data or completes.
- R8: Interrupt bit 31 (command done) and bit 28 (data done) are sticky. Writing 1 to a bit of register 5 clears only that bit. When a hardware set and a software clear meet in the same cycle, the set wins.
- R9: Busy reads 1 from the start until completion. A start word written while busy is ignored and produces no bus activity.
- R10: A start word with both bit 26 and bit 25 set is rejected: busy stays 0 and no bus cycle occurs.
- R11: CLE and ALE are never high together, WE_n and RE_n are never low together, and each WE_n low pulse lasts exactly STROBE_CYC clocks.
- R12: Data done (bit 28) is set only by operations that have a data phase; a data-less operation sets only bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| buf_we | input | 1 | Host page buffer write (ignored while busy) |
| buf_addr | input | AW | Host page buffer index |
| buf_wdata | input | 8 | Host page buffer write byte |
| buf_rdata | output | 8 | Host page buffer read byte |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus in |
| nand_rb_n | input | 1 | Ready/busy from the device, low = busy |
| irq | output | 1 | OR of the two sticky interrupt bits |

## Verification
The hardware setting of the command-done bit and a software write-one-to-clear of the same bit can land on the same clock. To provoke this, the bench writes a clear to bit 31 on every cycle while a data-less operation is running. It then watches the irq pin. The pin must rise for exactly one cycle at completion, which shows the set won over the coincident clear before the next clear removed it. A design where the clear wins never shows the pulse.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam logic [2:0] RA_START   = 3'd0;
    localparam logic [2:0] RA_ADDR_LO = 3'd1;
    localparam logic [2:0] RA_ADDR_HI = 3'd2;
    localparam logic [2:0] RA_CMD2    = 3'd3;
    localparam logic [2:0] RA_DLEN    = 3'd4;
    localparam logic [2:0] RA_IRQ     = 3'd5;
    localparam logic [2:0] RA_STATUS  = 3'd6;

    localparam int B_GO       = 31;
    localparam int B_APRES    = 30;
    localparam int B_RD       = 26;
    localparam int B_WR       = 25;
    localparam int B_CMD2_EN  = 8;
    localparam int B_IRQ_CMD  = 31;
    localparam int B_IRQ_DATA = 28;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD1, ST_ADDR, ST_CMD2, ST_WDATA, ST_SETTLE, ST_WAIT, ST_RDATA
    } seq_state_t;

    typedef struct packed {
        logic [7:0]  cmd1;
        logic [3:0]  naddr;
        logic        rd;
        logic        wr;
        logic        cmd2_en;
        logic [7:0]  cmd2;
        logic [15:0] addr_lo;
        logic [31:0] addr_hi;
    } op_t;

    // Number of address cycles implied by a start word.
    function automatic logic [3:0] addr_count(input logic [31:0] w);
        if (w[B_APRES])
            return {1'b0, w[29:27]} + 4'd1;
        else if (w[B_RD])
            return 4'd1;
        else
            return 4'd0;
    endfunction

    // Address byte n of the 48-bit address, zero beyond it.
    function automatic logic [7:0] addr_byte(input logic [15:0] lo,
                                             input logic [31:0] hi,
                                             input logic [2:0]  n);
        logic [63:0] all;
        all = {16'h0000, hi, lo};
        return all[{n, 3'b000} +: 8];
    endfunction

endpackage

// File: rtl/nand_seq_pagebuf.sv
module nand_seq_pagebuf #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
    import nand_seq_pkg::*;
#(
    parameter int DLEN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              set_cmd_done,
    input  logic              set_data_done,
    output logic              start,
    output op_t               op,
    output logic [DLEN_W-1:0] dlen,
    output logic              irq_cmd,
    output logic              irq_data
);
    logic [15:0] addr_lo_q;
    logic [31:0] addr_hi_q;
    logic [8:0]  cmd2_q;
    logic        clr_cmd;
    logic        clr_data;
    logic        wr_start;

    assign wr_start = reg_we && (reg_addr == RA_START);
    assign start    = wr_start && reg_wdata[B_GO] && !busy
                      && !(reg_wdata[B_RD] && reg_wdata[B_WR]);
    assign clr_cmd  = reg_we && (reg_addr == RA_IRQ) && reg_wdata[B_IRQ_CMD];
    assign clr_data = reg_we && (reg_addr == RA_IRQ) && reg_wdata[B_IRQ_DATA];

    always_comb begin
        op.cmd1    = reg_wdata[7:0];
        op.naddr   = addr_count(reg_wdata);
        op.rd      = reg_wdata[B_RD];
        op.wr      = reg_wdata[B_WR];
        op.cmd2_en = cmd2_q[B_CMD2_EN];
        op.cmd2    = cmd2_q[7:0];
        op.addr_lo = addr_lo_q;
        op.addr_hi = addr_hi_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            cmd2_q    <= '0;
            dlen      <= '0;
            irq_cmd   <= 1'b0;
            irq_data  <= 1'b0;
        end else begin
            if (reg_we) begin
                unique case (reg_addr)
                    RA_ADDR_LO: addr_lo_q <= reg_wdata[15:0];
                    RA_ADDR_HI: addr_hi_q <= reg_wdata;
                    RA_CMD2:    cmd2_q    <= reg_wdata[8:0];
                    RA_DLEN:    dlen      <= reg_wdata[DLEN_W-1:0];
                    default: ;
                endcase
            end
            // hardware set dominates a coincident clear
            irq_cmd  <= set_cmd_done  | (irq_cmd  & ~clr_cmd);
            irq_data <= set_data_done | (irq_data & ~clr_data);
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_ADDR_LO: reg_rdata[15:0] = addr_lo_q;
            RA_ADDR_HI: reg_rdata = addr_hi_q;
            RA_CMD2:    reg_rdata[8:0] = cmd2_q;
            RA_DLEN:    reg_rdata[DLEN_W-1:0] = dlen;
            RA_IRQ: begin
                reg_rdata[B_IRQ_CMD]  = irq_cmd;
                reg_rdata[B_IRQ_DATA] = irq_data;
            end
            RA_STATUS:  reg_rdata[0] = busy;
            default: ;
        endcase
    end
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int STROBE_CYC = 2,
    parameter int HOLD_CYC   = 2,
    parameter int SETTLE_CYC = 25,
    parameter int DLEN_W     = 8,
    localparam int CYC_LEN   = STROBE_CYC + HOLD_CYC,
    localparam int CNT_MAX   = (CYC_LEN > SETTLE_CYC) ? CYC_LEN : SETTLE_CYC,
    localparam int CNT_W     = $clog2(CNT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  op_t               op_in,
    input  logic [DLEN_W-1:0] dlen_in,
    input  logic              rb_n,
    input  logic [7:0]        dq_in,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    output logic              busy,
    output logic              cmd_done,
    output logic              data_done,
    output logic [DLEN_W-1:0] buf_raddr,
    input  logic [7:0]        buf_rdata,
    output logic              buf_we,
    output logic [DLEN_W-1:0] buf_waddr,
    output logic [7:0]        buf_wdata
);
    seq_state_t        state, nxt, post_addr;
    op_t               op_q;
    logic [DLEN_W-1:0] dlen_q;
    logic [CNT_W-1:0]  cnt;
    logic [DLEN_W-1:0] idx;
    logic              bus_state;
    logic              strobe_low;
    logic              cyc_end;
    logic              last_addr;
    logic              last_data;

    assign bus_state  = (state == ST_CMD1) || (state == ST_ADDR) || (state == ST_CMD2)
                        || (state == ST_WDATA) || (state == ST_RDATA);
    assign strobe_low = bus_state && (cnt < CNT_W'(STROBE_CYC));
    assign cyc_end    = bus_state && (cnt == CNT_W'(CYC_LEN - 1));
    assign last_addr  = (idx == DLEN_W'(op_q.naddr - 4'd1));
    assign last_data  = (idx == dlen_q);
    assign busy       = (state != ST_IDLE);

    assign post_addr = op_q.wr ? ST_WDATA : (op_q.cmd2_en ? ST_CMD2 : ST_SETTLE);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_CMD1:  nxt = (op_q.naddr != 4'd0) ? ST_ADDR : post_addr;
            ST_ADDR:  nxt = last_addr ? post_addr : ST_ADDR;
            ST_WDATA: nxt = last_data ? (op_q.cmd2_en ? ST_CMD2 : ST_SETTLE) : ST_WDATA;
            ST_CMD2:  nxt = ST_SETTLE;
            ST_RDATA: nxt = last_data ? ST_IDLE : ST_RDATA;
            default:  nxt = state;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            op_q   <= '0;
            dlen_q <= '0;
            cnt    <= '0;
            idx    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    op_q   <= op_in;
                    dlen_q <= dlen_in;
                    cnt    <= '0;
                    idx    <= '0;
                    state  <= ST_CMD1;
                end
                ST_SETTLE: begin
                    if (cnt == CNT_W'(SETTLE_CYC - 1)) begin
                        cnt   <= '0;
                        state <= ST_WAIT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WAIT: if (rb_n) begin
                    cnt   <= '0;
                    idx   <= '0;
                    state <= op_q.rd ? ST_RDATA : ST_IDLE;
                end
                default: begin
                    if (cyc_end) begin
                        cnt   <= '0;
                        idx   <= (nxt == state) ? idx + 1'b1 : '0;
                        state <= nxt;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign cmd_done  = ((state == ST_WAIT) && rb_n && !op_q.rd)
                     || ((state == ST_RDATA) && cyc_end && last_data);
    assign data_done = ((state == ST_WDATA) || (state == ST_RDATA)) && cyc_end && last_data;

    // bus pins
    assign cle   = (state == ST_CMD1) || (state == ST_CMD2);
    assign ale   = (state == ST_ADDR);
    assign dq_oe = cle || ale || (state == ST_WDATA);
    assign we_n  = !(dq_oe && strobe_low);
    assign re_n  = !((state == ST_RDATA) && strobe_low);

    always_comb begin
        unique case (state)
            ST_CMD1:  dq_out = op_q.cmd1;
            ST_CMD2:  dq_out = op_q.cmd2;
            ST_ADDR:  dq_out = addr_byte(op_q.addr_lo, op_q.addr_hi, idx[2:0]);
            ST_WDATA: dq_out = buf_rdata;
            default:  dq_out = 8'h00;
        endcase
    end

    // page buffer side: capture at the edge where RE_n rises
    assign buf_raddr = idx;
    assign buf_waddr = idx;
    assign buf_wdata = dq_in;
    assign buf_we    = (state == ST_RDATA) && (cnt == CNT_W'(STROBE_CYC - 1));
endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
    import nand_seq_pkg::*;
#(
    parameter int STROBE_CYC = 2,
    parameter int HOLD_CYC   = 2,
    parameter int SETTLE_CYC = 25,
    parameter int BUF_DEPTH  = 256,
    localparam int AW        = $clog2(BUF_DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          buf_we,
    input  logic [AW-1:0] buf_addr,
    input  logic [7:0]    buf_wdata,
    output logic [7:0]    buf_rdata,
    output logic          nand_cle,
    output logic          nand_ale,
    output logic          nand_we_n,
    output logic          nand_re_n,
    output logic [7:0]    nand_dq_out,
    output logic          nand_dq_oe,
    input  logic [7:0]    nand_dq_in,
    input  logic          nand_rb_n,
    output logic          irq
);
    op_t           op;
    logic [AW-1:0] dlen;
    logic          start, busy, cmd_done, data_done;
    logic          irq_cmd, irq_data;
    logic          eng_we;
    logic [AW-1:0] eng_raddr, eng_waddr;
    logic [7:0]    eng_rdata, eng_wdata;
    logic          pb_we;
    logic [AW-1:0] pb_waddr;
    logic [7:0]    pb_wdata;

    nand_seq_regs #(.DLEN_W(AW)) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .set_cmd_done(cmd_done), .set_data_done(data_done),
        .start(start), .op(op), .dlen(dlen), .irq_cmd(irq_cmd), .irq_data(irq_data)
    );

    nand_seq_fsm #(
        .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC),
        .SETTLE_CYC(SETTLE_CYC), .DLEN_W(AW)
    ) u_fsm (
        .clk(clk), .rst(rst), .start(start), .op_in(op), .dlen_in(dlen),
        .rb_n(nand_rb_n), .dq_in(nand_dq_in),
        .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
        .dq_out(nand_dq_out), .dq_oe(nand_dq_oe),
        .busy(busy), .cmd_done(cmd_done), .data_done(data_done),
        .buf_raddr(eng_raddr), .buf_rdata(eng_rdata),
        .buf_we(eng_we), .buf_waddr(eng_waddr), .buf_wdata(eng_wdata)
    );

    // the engine owns the write port while busy
    assign pb_we    = busy ? eng_we : buf_we;
    assign pb_waddr = busy ? eng_waddr : buf_addr;
    assign pb_wdata = busy ? eng_wdata : buf_wdata;

    nand_seq_pagebuf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .we(pb_we), .waddr(pb_waddr), .wdata(pb_wdata),
        .raddr_a(eng_raddr), .rdata_a(eng_rdata),
        .raddr_b(buf_addr), .rdata_b(buf_rdata)
    );

    assign irq = irq_cmd | irq_data;
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk
    import nand_seq_pkg::*;
#(
    parameter int STROBE_CYC = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        cle,
    input logic        ale,
    input logic        we_n,
    input logic        re_n,
    input logic        busy,
    input logic        rb_n,
    input logic        reg_we,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        irq_cmd
);
    logic [7:0] wl_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            wl_cnt <= '0;
        else if (!we_n)
            wl_cnt <= wl_cnt + 1'b1;
        else
            wl_cnt <= '0;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (we_n && re_n && !cle && !ale));

    assert_start_source_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(reg_we) && $past(reg_addr) == RA_START && $past(reg_wdata[B_GO])));

    assert_ready_before_done_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(rb_n));

    assert_done_flag_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq_cmd);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_cmd && !(reg_we && reg_addr == RA_IRQ && reg_wdata[B_IRQ_CMD])) |=> irq_cmd);

    assert_latch_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n));

    assert_we_width_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (wl_cnt == 8'(STROBE_CYC)));
endmodule

bind nand_seq_top nand_seq_chk #(.STROBE_CYC(STROBE_CYC)) u_chk (
    .clk(clk), .rst(rst), .cle(nand_cle), .ale(nand_ale),
    .we_n(nand_we_n), .re_n(nand_re_n), .busy(busy), .rb_n(nand_rb_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_cmd(irq_cmd)
);

// File: tb/nand_seq_top_tb.sv
module nand_seq_top_tb;
    localparam int AW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        buf_we = 1'b0;
    logic [AW-1:0] buf_addr = '0;
    logic [7:0]  buf_wdata = 8'd0;
    logic [7:0]  buf_rdata;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, irq;
    logic [7:0]  nand_dq_out;
    logic [7:0]  nand_dq_in = 8'd0;
    logic        nand_rb_n = 1'b1;

    int checks = 0;
    int failures = 0;
    int log_n = 0;
    int log_kind [64];
    logic [7:0] log_val [64];
    int busy_req = 0, busy_seen = 0, dev_dly = 0, dev_busy = 0;
    int rd_count = 0;
    int re_while_busy = 0, early_done = 0;
    logic prev_irq = 1'b0;
    int cycles = 0;

    always #2 clk = ~clk;

    nand_seq_top u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n), .irq(irq)
    );

    // device model: latch cycles, go busy after confirm/reset commands
    always @(posedge nand_we_n) begin
        if (!rst && log_n < 64) begin
            log_kind[log_n] = nand_cle ? 1 : (nand_ale ? 2 : 3);
            log_val[log_n]  = nand_dq_out;
            log_n = log_n + 1;
            if (nand_cle && (nand_dq_out == 8'h30 || nand_dq_out == 8'h10 || nand_dq_out == 8'hFF))
                busy_req = busy_req + 1;
        end
    end

    always @(negedge nand_re_n) begin
        nand_dq_in = 8'hA0 + 8'(rd_count);
        rd_count = rd_count + 1;
    end

    always @(negedge clk) begin
        cycles = cycles + 1;
        if (busy_req != busy_seen) begin
            busy_seen = busy_req;
            dev_dly = 5;
        end else if (dev_dly > 0) begin
            dev_dly = dev_dly - 1;
            if (dev_dly == 0) begin
                nand_rb_n = 1'b0;
                dev_busy = 60;
            end
        end else if (dev_busy > 0) begin
            dev_busy = dev_busy - 1;
            if (dev_busy == 0) nand_rb_n = 1'b1;
        end
        if (!nand_re_n && !nand_rb_n) re_while_busy = re_while_busy + 1;
        if (irq && !prev_irq && (!nand_rb_n || dev_dly > 0)) early_done = early_done + 1;
        prev_irq = irq;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic buf_put(input int a, input logic [7:0] d);
        @(negedge clk);
        buf_we = 1'b1; buf_addr = AW'(a); buf_wdata = d;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic buf_get(input int a, output logic [7:0] d);
        @(negedge clk);
        buf_addr = AW'(a);
        #1 d = buf_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 5000; i++) begin
            rd(3'd6, s);
            if (s[0] == 1'b0) break;
        end
    endtask

    task automatic prep();
        wait_idle();
        repeat (80) @(negedge clk);
        wr(3'd5, 32'h9000_0000);
        log_n = 0;
        rd_count = 0;
    endtask

    task automatic exp_log(input int i, input int kind, input logic [7:0] v, input string req);
        chk(i < log_n && log_kind[i] == kind && log_val[i] == v, req,
            (i < log_n) ? {log_kind[i], 8'(log_val[i])} : 32'hdead, {kind, 8'(v)});
    endtask

    task automatic t_reset();
        logic [31:0] s;
        rd(3'd6, s); chk(s == 0, "R1 status", s, 0);
        rd(3'd5, s); chk(s == 0, "R1 irq", s, 0);
        chk(nand_we_n && nand_re_n && !nand_cle && !nand_ale, "R1 pins",
            {nand_we_n, nand_re_n, nand_cle, nand_ale}, 4'b1100);
    endtask

    task automatic t_id_read();
        logic [31:0] s; logic [7:0] b;
        prep();
        buf_put(5, 8'hEE);
        wr(3'd3, 32'h0); wr(3'd1, 32'h0); wr(3'd4, 32'd4);
        wr(3'd0, 32'hC400_0090);
        wait_idle();
        chk(log_n == 2, "R2 id cycles", log_n, 2);
        exp_log(0, 1, 8'h90, "R2 first cmd");
        exp_log(1, 2, 8'h00, "R3 id addr");
        for (int i = 0; i < 5; i++) begin
            buf_get(i, b);
            chk(b == 8'hA0 + 8'(i), "R6 read byte", b, 8'hA0 + 8'(i));
        end
        buf_get(5, b); chk(b == 8'hEE, "R6 untouched", b, 8'hEE);
        rd(3'd5, s); chk(s == 32'h9000_0000, "R12 read flags", s, 32'h9000_0000);
    endtask

    task automatic t_zero_addr_read();
        logic [7:0] b;
        prep();
        wr(3'd3, 32'h0); wr(3'd1, 32'h00AB); wr(3'd4, 32'd0);
        wr(3'd0, 32'h8400_0070);
        wait_idle();
        chk(log_n == 2, "R4 cycles", log_n, 2);
        exp_log(1, 2, 8'hAB, "R4 forced addr");
        buf_get(0, b); chk(b == 8'hA0, "R6 single byte", b, 8'hA0);
    endtask

    task automatic t_page_read();
        logic [7:0] b;
        logic [7:0] ea [5] = '{8'h34, 8'h12, 8'h9A, 8'h78, 8'h56};
        prep();
        wr(3'd1, 32'h1234); wr(3'd2, 32'h0056_789A);
        wr(3'd3, 32'h130); wr(3'd4, 32'd7);
        wr(3'd0, 32'hE400_0000);
        wr(3'd0, 32'h8000_0070);   // arrives while busy: must be ignored
        wait_idle();
        chk(log_n == 7, "R9 ignored start", log_n, 7);
        exp_log(0, 1, 8'h00, "R2 read cmd");
        for (int i = 0; i < 5; i++) exp_log(i + 1, 2, ea[i], "R3 addr order");
        exp_log(6, 1, 8'h30, "R5 read confirm after addr");
        for (int i = 0; i < 8; i++) begin
            buf_get(i, b);
            chk(b == 8'hA0 + 8'(i), "R6 page byte", b, 8'hA0 + 8'(i));
        end
        chk(re_while_busy == 0, "R7 no read while busy", re_while_busy, 0);
        chk(early_done == 0, "R7 no early done", early_done, 0);
    endtask

    task automatic t_program();
        logic [31:0] s;
        logic [7:0] d [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
        prep();
        for (int i = 0; i < 4; i++) buf_put(i, d[i]);
        wr(3'd1, 32'h0200); wr(3'd3, 32'h110); wr(3'd4, 32'd3);
        wr(3'd0, 32'hCA00_0080);
        wait_idle();
        chk(log_n == 8, "R6 program cycles", log_n, 8);
        exp_log(1, 2, 8'h00, "R3 col lo");
        exp_log(2, 2, 8'h02, "R3 col hi");
        for (int i = 0; i < 4; i++) exp_log(i + 3, 3, d[i], "R6 write order");
        exp_log(7, 1, 8'h10, "R5 confirm after data");
        chk(early_done == 0, "R7 program done", early_done, 0);
        wr(3'd5, 32'h1000_0000);
        rd(3'd5, s); chk(s == 32'h8000_0000, "R8 clear only bit28", s, 32'h8000_0000);
        wr(3'd5, 32'h8000_0000);
        rd(3'd5, s); chk(s == 0, "R8 clear bit31", s, 0);
    endtask

    task automatic t_no_data();
        logic [31:0] s;
        prep();
        wr(3'd3, 32'h0);
        wr(3'd0, 32'h8000_00FF);
        wait_idle();
        chk(log_n == 1, "R12 single cycle", log_n, 1);
        exp_log(0, 1, 8'hFF, "R2 reset cmd");
        rd(3'd5, s); chk(s == 32'h8000_0000, "R12 only cmd done", s, 32'h8000_0000);
    endtask

    task automatic t_both_dirs();
        logic [31:0] s;
        prep();
        wr(3'd0, 32'h8600_0090);
        rd(3'd6, s); chk(s == 0, "R10 not busy", s, 0);
        repeat (40) @(negedge clk);
        chk(log_n == 0, "R10 no bus", log_n, 0);
    endtask

    task automatic t_collision();
        int seen = 0;
        prep();
        wr(3'd3, 32'h0);
        wr(3'd0, 32'h8000_00FF);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h8000_0000;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (irq) seen = seen + 1;
        end
        reg_we = 1'b0;
        chk(seen == 1, "R8 set wins over clear", seen, 1);
        chk(irq == 1'b0, "R8 cleared after", irq, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks = checks + 1;
        failures = failures + 1;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_id_read();
        t_zero_addr_read();
        t_page_read();
        t_program();
        t_no_data();
        t_both_dirs();
        t_collision();
        finish_run();
    end
endmodule